// File: doc/BRIEF.md
# Three-Digit Decimal Seconds Counter

This block keeps a free-running decimal count of elapsed seconds in three binary-coded-decimal digits, running from 000 to 999 and then starting over. A fast system clock (50 MHz by default) drives every register directly. A prescaler turns that clock into a strobe that is high for one cycle per second, and the strobe enables a chain of modulo-10 digit stages. No clock is ever divided or gated. A digit that must hold its value is held by its enable.

The count is available as packed BCD digits. When enabled by a parameter, it is also available as one active-low seven-segment pattern per digit. An active-low pushbutton input resets the count and the prescaler. The reset is synchronous to the clock, and it is assumed to be debounced and synchronised outside the block.

The prescaler terminal count is a parameter, so a short period can stand in for one second. The number of digits is a parameter too.

Top module: `bcd_sec_counter`

## Requirements
- R1: While `rst_btn_n` is low at a rising clock edge, every digit becomes 0. When segments are enabled, each segment group then shows the pattern for 0.
- R2: The count advances by exactly one every CLK_HZ clock cycles. Between advances all outputs hold their value.
- R3: The units digit (bits 3:0 of `bcd_o`) steps up by one on each advance. From 9 it wraps to 0.
- R4: The tens digit (bits 7:4) changes only on an advance at which the units digit is 9.
- R5: The hundreds digit (bits 11:8) changes only on an advance at which both lower digits are 9.
- R6: The advance that follows the all-nines count (999) gives 000.
- R7: Reset also clears the prescaler. After `rst_btn_n` returns high, the first advance comes exactly CLK_HZ rising edges later, whatever the prescaler phase was when reset was applied.
- R8: `seg_n_o[7*i+6 : 7*i]` is the active-low pattern for digit i, with bit 0 as segment a through bit 6 as segment g. The patterns, written as bits g..a, are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.
- R9: No digit ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; clocks every register in the block |
| rst_btn_n | input | 1 | Active-low reset from the pushbutton; sampled on the clock edge |
| bcd_o | output | 4*NUM_DIGITS (12) | Packed BCD count; the units digit is in the lowest nibble |
| seg_n_o | output | 7*NUM_DIGITS (21) | Active-low seven-segment patterns, 7 bits per digit; all ones when SEG_EN is 0 |

## Verification
The bench builds the block with CLK_HZ set to 5 and the default three digits and segment decoding. With that setting a simulated "second" lasts five cycles. The whole range 000 to 999, including the wrap-around, therefore fits in about five thousand cycles. The short period also puts every carry boundary in reach: 009 to 010, 099 to 100 and 999 to 000. It lets a reset land at a chosen prescaler phase, so the bench can show that the next advance counts a full period from the release of reset.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;

  localparam bcd_t DIGIT_MAX = 4'd9;

  // Active-low pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t seg_of(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] TC = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == TC);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  // R2: the phase counter never leaves its period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TC);

  // R2: a strobe restarts the period
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R2: without a strobe the phase moves forward by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R7: reset leaves the prescaler at phase zero
  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> (cnt_q == '0));

endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  output bcd_t val_o,
  output logic carry_o
);

  bcd_t val_q;

  assign val_o   = val_q;
  assign carry_o = inc_i && (val_q == DIGIT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      val_q <= '0;
    else if (inc_i)
      val_q <= (val_q == DIGIT_MAX) ? bcd_t'(0) : val_q + bcd_t'(1);
  end

  // R9: digit stays decimal
  p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= DIGIT_MAX);

  // R4: without an enable the digit holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(val_q));

  // R3: nine wraps to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && val_q == DIGIT_MAX) |=> (val_q == '0));

  // R3: below nine the digit steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && val_q != DIGIT_MAX) |=> (val_q == $past(val_q) + bcd_t'(1)));

  // R1: reset clears the digit
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (val_q == '0));

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_cnt_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_n_o
);

  assign seg_n_o = seg_of(digit_i);

  // R8: a decimal digit always lights at least two segments
  always_comb begin
    if (digit_i <= DIGIT_MAX)
      p_seg_lit_r8: assert ($countones(~seg_n_o) >= 2);
  end

endmodule

// File: rtl/bcd_sec_counter.sv
module bcd_sec_counter
  import bcd_cnt_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned NUM_DIGITS = 3,
  parameter bit          SEG_EN     = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_btn_n,
  output logic [NUM_DIGITS*DIGIT_W-1:0] bcd_o,
  output logic [NUM_DIGITS*SEG_W-1:0]   seg_n_o
);

  localparam int unsigned BCD_W = NUM_DIGITS * DIGIT_W;

  logic                tick;
  logic [NUM_DIGITS:0] inc_chain;
  bcd_t                digit [NUM_DIGITS];

  tick_prescaler #(.CLK_HZ(CLK_HZ)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_btn_n),
    .tick_o (tick)
  );

  assign inc_chain[0] = tick;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    bcd_digit_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_btn_n),
      .inc_i   (inc_chain[gi]),
      .val_o   (digit[gi]),
      .carry_o (inc_chain[gi+1])
    );
    assign bcd_o[gi*DIGIT_W +: DIGIT_W] = digit[gi];

    if (SEG_EN) begin : g_seg
      bcd_seg_decoder u_seg (
        .digit_i (digit[gi]),
        .seg_n_o (seg_n_o[gi*SEG_W +: SEG_W])
      );
    end else begin : g_noseg
      assign seg_n_o[gi*SEG_W +: SEG_W] = '1;
    end
  end

  logic all_nines;
  always_comb begin
    all_nines = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (digit[i] != DIGIT_MAX) all_nines = 1'b0;
  end

  // R2: the whole count holds between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_btn_n)
    !tick |=> $stable(bcd_o));

  // R6: full count rolls over to zero
  p_wrap_all_r6: assert property (@(posedge clk) disable iff (!rst_btn_n)
    (tick && all_nines) |=> (bcd_o == '0));

  // R5: the top carry leaves only from all-nines
  p_top_carry_r5: assert property (@(posedge clk) disable iff (!rst_btn_n)
    inc_chain[NUM_DIGITS] |-> all_nines);

  // R1: reset clears the whole count
  p_reset_all_r1: assert property (@(posedge clk)
    !rst_btn_n |=> (bcd_o == BCD_W'(0)));

endmodule

// File: tb/bcd_sec_counter_tb.sv
module bcd_sec_counter_tb;

  localparam int unsigned HZ = 5;
  localparam int unsigned ND = 3;

  logic              clk = 1'b0;
  logic              rst_btn_n = 1'b0;
  logic [ND*4-1:0]   bcd;
  logic [ND*7-1:0]   seg_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bcd_sec_counter #(.CLK_HZ(HZ), .NUM_DIGITS(ND), .SEG_EN(1'b1)) u_dut (
    .clk       (clk),
    .rst_btn_n (rst_btn_n),
    .bcd_o     (bcd),
    .seg_n_o   (seg_n)
  );

  // cycles to run from the previous vector, expected decimal count
  localparam int NV = 10;
  localparam int VEC_CYC [NV] = '{5, 4, 1, 35, 5, 445, 5, 4495, 4, 1};
  localparam int VEC_EXP [NV] = '{1, 1, 2, 9, 10, 99, 100, 999, 999, 0};
  localparam string VEC_REQ [NV] = '{"R3", "R2", "R3", "R3", "R4", "R4",
                                     "R5", "R5", "R2", "R6"};

  function automatic logic [6:0] seg_ref(input int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      default: return 7'b0010000;
    endcase
  endfunction

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int value);
    logic [ND*4-1:0] exp_bcd;
    logic [ND*7-1:0] exp_seg;
    int v = value;
    for (int i = 0; i < ND; i++) begin
      exp_bcd[i*4 +: 4] = 4'(v % 10);
      exp_seg[i*7 +: 7] = seg_ref(v % 10);
      v = v / 10;
    end
    n_checks++;
    if (bcd !== exp_bcd) begin
      n_fail++;
      $display("FAIL %s count: actual %h expected %h", req, bcd, exp_bcd);
    end
    n_checks++;
    if (seg_n !== exp_seg) begin
      n_fail++;
      $display("FAIL %s R8 segments: actual %b expected %b", req, seg_n, exp_seg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0);
    rst_btn_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      run(VEC_CYC[k]);
      check(VEC_REQ[k], VEC_EXP[k]);
    end
    // directed: reset in mid-count returns to zero
    run(3 * HZ + 2);
    check("R2", 3);
    rst_btn_n = 1'b0;
    run(2);
    check("R1", 0);
    rst_btn_n = 1'b1;
    run(HZ - 1);
    check("R7", 0);
    run(1);
    check("R7", 1);
    // directed: reset at a late prescaler phase must restart the period
    run(HZ - 2);
    check("R7", 1);
    rst_btn_n = 1'b0;
    run(1);
    rst_btn_n = 1'b1;
    run(HZ - 1);
    check("R7", 0);
    run(1);
    check("R7", 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule